// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block models the write-command interface of a byte-wide parallel NOR flash as a synchronous state machine. A host drives chip enable, write enable and output enable (all active low), an address and a data byte. These strobes are sampled on the system clock. Bus write cycles are reduced to single write events. The address is captured when a write cycle opens and the data byte when it closes. The events are fed to a sequence recognizer that accepts only the protected unlock sequences for byte program, sector erase and chip erase.

Once a sequence completes, the block enters a busy phase whose length is a clock count that depends on the operation. The change to the internal array is applied at the end of that phase. While busy, the block ignores every write and answers reads with status instead of array data. The status byte carries a polling bit and a bit that alternates on each read.

The storage is small on purpose. The address is split into 4 KiB sectors (bits 12 and up), and only the lowest `OFF_BITS` offset bits within a sector are stored. The offset bits from `OFF_BITS` up to 11 are ignored, so addresses that differ only there alias to the same byte. The strobes are plain control pins. The data bus is split into `dq_in`, `dq_out` and a drive enable `dq_oe`, and it has no flow control, so neither side can stall the other.

Top module: `pflash_cmd_decoder`

## Requirements
- R1: After reset, every stored byte reads 0xFF, the recognizer is idle and no operation is busy.
- R2: A write cycle is the interval where `ce_n` and `we_n` are both low. The address is taken in the first clock of that interval, which is the later of the two falling edges. The data byte is the last value sampled before the earlier of the two rising edges. Address or data changes made in between have no effect.
- R3: Byte program is 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555, then data D to address A. Only the low 15 address bits are compared for the unlock addresses. At completion the byte at A becomes old AND D, so a program can only clear bits.
- R4: Sector erase is 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA, then 0x30 to any address in the sector. At completion every byte of the sector selected by address bits 15..12 reads 0xFF, and other sectors are unchanged.
- R5: Chip erase uses the same first five cycles as R4, then 0x10 to 0x5555. At completion every byte reads 0xFF.
- R6: A write whose address or data does not match the value expected at that point returns the recognizer to idle with no change to the array.
- R7: While an operation is busy, every write is ignored. It neither advances the recognizer nor starts or alters an operation.
- R8: A read while busy returns bit 7 equal to the complement of the programmed data bit 7 for a program, and 0 for either erase. Bits 5..0 read 0.
- R9: While busy, bit 6 reads 0 on the first read after the operation starts and inverts on each following read.
- R10: `dq_oe` is high exactly when `ce_n` and `oe_n` are both low. When it is low, `dq_out` is 0x00. When it is high and the block is idle, `dq_out` is the stored byte at `addr`.
- R11: Busy lasts exactly `T_PGM`, `T_SECT` or `T_CHIP` clocks for program, sector erase and chip erase, counted from the clock after the final write closes. After that the array holds the new value.
- R12: Address bits `OFF_BITS` to 11 select nothing. Two addresses that differ only in those bits read and program the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Byte address |
| dq_in | input | 8 | Data byte written by the host |
| dq_out | output | 8 | Read data or status byte |
| dq_oe | output | 1 | High when the block drives the data bus |

## Verification
Every bench write moves the address after the cycle opens and changes the data just before it closes. A decoder that latched the wrong instant would therefore program the wrong byte, or the wrong value, and fail the readback. Busy windows are loaded with writes: a chip-erase sequence sent during a sector erase, and an unlock byte sent during a program whose sequence is finished after completion. A design that listened while busy would wipe the preserved sector or program a byte that must stay 0xFF. Broken sequences, with a bad data value or a bad unlock address, must leave the array untouched. Status reads check the polling bit for program and erase, and check that bit 6 alternates from a known first value. A fixed-seed random program phase compares AND semantics and sector aliasing against a shadow model.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0]  CMD_UNLK1 = 8'hAA;
  localparam logic [7:0]  CMD_UNLK2 = 8'h55;
  localparam logic [7:0]  CMD_PGM   = 8'hA0;
  localparam logic [7:0]  CMD_ERS   = 8'h80;
  localparam logic [7:0]  CMD_SECT  = 8'h30;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;
  localparam logic [14:0] ADR_A     = 15'h5555;
  localparam logic [14:0] ADR_B     = 15'h2AAA;

  typedef enum logic [1:0] {OP_PGM, OP_SECT, OP_CHIP} op_e;
  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PGM, S_E1, S_E2, S_E3} seq_e;
endpackage

// File: rtl/pflash_bus_capture.sv
module pflash_bus_capture #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    dq_in,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          rd_end
);
  logic wr_act, rd_act, wr_q, rd_q;

  assign wr_act = !ce_n && !we_n;
  assign rd_act = !ce_n && !oe_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      // address: first clock where both strobes are low (later falling edge)
      if (wr_act && !wr_q) wr_addr <= addr;
      // data: keep the last sample before the earlier rising edge
      if (wr_act) wr_data <= dq_in;
    end
  end

  assign wr_evt = wr_q && !wr_act;
  assign rd_end = rd_q && !rd_act;
endmodule

// File: rtl/pflash_seq_fsm.sv
module pflash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW = 16,
  parameter int UW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_evt,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          busy,
  output logic          launch,
  output op_e           launch_op,
  output logic [AW-1:0] launch_addr,
  output logic [7:0]    launch_data,
  output seq_e          state
);
  seq_e nxt;

  function automatic logic hit(input logic [AW-1:0] a, input logic [7:0] d,
                               input logic [14:0] ea, input logic [7:0] ed);
    return (a[UW-1:0] == ea[UW-1:0]) && (d == ed);
  endfunction

  always_comb begin
    nxt       = state;
    launch    = 1'b0;
    launch_op = OP_PGM;
    if (wr_evt && !busy) begin
      unique case (state)
        S_IDLE: nxt = hit(wr_addr, wr_data, ADR_A, CMD_UNLK1) ? S_U1 : S_IDLE;
        S_U1:   nxt = hit(wr_addr, wr_data, ADR_B, CMD_UNLK2) ? S_U2 : S_IDLE;
        S_U2: begin
          if (hit(wr_addr, wr_data, ADR_A, CMD_PGM))      nxt = S_PGM;
          else if (hit(wr_addr, wr_data, ADR_A, CMD_ERS)) nxt = S_E1;
          else                                            nxt = S_IDLE;
        end
        S_PGM: begin
          launch = 1'b1;
          nxt    = S_IDLE;
        end
        S_E1: nxt = hit(wr_addr, wr_data, ADR_A, CMD_UNLK1) ? S_E2 : S_IDLE;
        S_E2: nxt = hit(wr_addr, wr_data, ADR_B, CMD_UNLK2) ? S_E3 : S_IDLE;
        S_E3: begin
          nxt = S_IDLE;
          if (wr_data == CMD_SECT) begin
            launch    = 1'b1;
            launch_op = OP_SECT;
          end else if (hit(wr_addr, wr_data, ADR_A, CMD_CHIP)) begin
            launch    = 1'b1;
            launch_op = OP_CHIP;
          end
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  assign launch_addr = wr_addr;
  assign launch_data = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/pflash_busy_timer.sv
module pflash_busy_timer
  import flash_cmd_pkg::*;
#(
  parameter int T_PGM  = 16,
  parameter int T_SECT = 48,
  parameter int T_CHIP = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  op_e  op,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(T_CHIP + 1);
  logic [CW-1:0] cnt_q, load;

  always_comb begin
    unique case (op)
      OP_SECT: load = CW'(T_SECT - 1);
      OP_CHIP: load = CW'(T_CHIP - 1);
      default: load = CW'(T_PGM - 1);
    endcase
  end

  assign done = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (launch) begin
      busy  <= 1'b1;
      cnt_q <= load;
    end else if (busy) begin
      if (done) busy  <= 1'b0;
      else      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pflash_array.sv
module pflash_array
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 16,
  parameter int OFF_BITS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  op_e           op,
  input  logic [AW-1:0] op_addr,
  input  logic [7:0]    op_data,
  input  logic          done,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          pol_bit
);
  localparam int SB    = AW - 12;
  localparam int IW    = SB + OFF_BITS;
  localparam int DEPTH = 1 << IW;
  localparam int SWORD = 1 << OFF_BITS;

  logic [7:0]    mem [DEPTH];
  op_e           op_q;
  logic [IW-1:0] idx_q;
  logic [7:0]    dat_q;
  logic [IW-1:0] op_idx, rd_idx;
  logic          unused_bits;

  assign op_idx      = {op_addr[AW-1:12], op_addr[OFF_BITS-1:0]};
  assign rd_idx      = {rd_addr[AW-1:12], rd_addr[OFF_BITS-1:0]};
  assign unused_bits = ^{op_addr[11:OFF_BITS], rd_addr[11:OFF_BITS]};
  assign rd_data     = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      op_q    <= OP_PGM;
      idx_q   <= '0;
      dat_q   <= 8'hFF;
      pol_bit <= 1'b1;
    end else begin
      if (launch) begin
        op_q    <= op;
        idx_q   <= op_idx;
        dat_q   <= op_data;
        pol_bit <= (op == OP_PGM) ? op_data[7] : 1'b1;
      end
      if (done) begin
        unique case (op_q)
          OP_PGM: mem[idx_q] <= mem[idx_q] & dat_q;
          OP_SECT:
            for (int i = 0; i < SWORD; i++)
              mem[{idx_q[IW-1:OFF_BITS], i[OFF_BITS-1:0]}] <= 8'hFF;
          default:
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/pflash_cmd_decoder.sv
module pflash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 16,
  parameter int UW       = 15,
  parameter int OFF_BITS = 3,
  parameter int T_PGM    = 16,
  parameter int T_SECT   = 48,
  parameter int T_CHIP   = 96
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    dq_in,
  output logic [7:0]    dq_out,
  output logic          dq_oe
);
  logic          wr_evt, rd_end, launch, busy, done, pol_bit, tog_q;
  logic [AW-1:0] wr_addr, l_addr;
  logic [7:0]    wr_data, l_data, rd_data;
  op_e           l_op;
  seq_e          seq_state;

  pflash_bus_capture #(.AW(AW)) u_cap (
    .clk, .rst_n, .ce_n, .we_n, .oe_n, .addr, .dq_in,
    .wr_evt, .wr_addr, .wr_data, .rd_end
  );

  pflash_seq_fsm #(.AW(AW), .UW(UW)) u_fsm (
    .clk, .rst_n, .wr_evt, .wr_addr, .wr_data, .busy,
    .launch, .launch_op(l_op), .launch_addr(l_addr), .launch_data(l_data),
    .state(seq_state)
  );

  pflash_busy_timer #(.T_PGM(T_PGM), .T_SECT(T_SECT), .T_CHIP(T_CHIP)) u_tmr (
    .clk, .rst_n, .launch, .op(l_op), .busy, .done
  );

  pflash_array #(.AW(AW), .OFF_BITS(OFF_BITS)) u_arr (
    .clk, .rst_n, .launch, .op(l_op), .op_addr(l_addr), .op_data(l_data),
    .done, .rd_addr(addr), .rd_data, .pol_bit
  );

  // alternating status bit: cleared at start, inverted at the end of each busy read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              tog_q <= 1'b0;
    else if (launch)         tog_q <= 1'b0;
    else if (rd_end && busy) tog_q <= ~tog_q;
  end

  assign dq_oe  = !ce_n && !oe_n;
  assign dq_out = !dq_oe ? 8'h00 : (busy ? {~pol_bit, tog_q, 6'b0} : rd_data);
endmodule

// File: rtl/pflash_cmd_decoder_chk.sv
module pflash_cmd_decoder_chk
  import flash_cmd_pkg::*;
#(
  parameter int T_PGM  = 16,
  parameter int T_SECT = 48,
  parameter int T_CHIP = 96
) (
  input logic       clk,
  input logic       rst_n,
  input logic       launch,
  input op_e        l_op,
  input logic       busy,
  input logic       done,
  input seq_e       seq_state,
  input logic       ce_n,
  input logic       oe_n,
  input logic [7:0] dq_out
);
  int unsigned cnt_q;
  op_e         op_q;
  int unsigned exp_dur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 0;
      op_q  <= OP_PGM;
    end else if (launch) begin
      cnt_q <= 0;
      op_q  <= l_op;
    end else if (busy) begin
      cnt_q <= cnt_q + 1;
    end
  end

  always_comb begin
    unique case (op_q)
      OP_SECT: exp_dur = T_SECT;
      OP_CHIP: exp_dur = T_CHIP;
      default: exp_dur = T_PGM;
    endcase
  end

  // R7
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> seq_state == S_IDLE);

  // R7
  no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);

  // R11
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R11
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt_q + 1 == exp_dur));

  // R8
  status_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ce_n && !oe_n) |-> dq_out[5:0] == 6'b0);
endmodule

bind pflash_cmd_decoder pflash_cmd_decoder_chk #(
  .T_PGM(T_PGM), .T_SECT(T_SECT), .T_CHIP(T_CHIP)
) u_chk (
  .clk, .rst_n, .launch, .l_op, .busy, .done, .seq_state,
  .ce_n, .oe_n, .dq_out
);

// File: tb/pflash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module pflash_cmd_decoder_tb;
  localparam int AW = 16, OFFB = 3;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dq_in = '0;
  logic [7:0]    dq_out;
  logic          dq_oe;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] shadow [128];

  always #2 clk = ~clk;

  pflash_cmd_decoder u_dut (.clk, .rst_n, .ce_n, .we_n, .oe_n, .addr, .dq_in,
                            .dq_out, .dq_oe);

  function automatic int midx(input logic [15:0] a);
    return int'({a[15:12], a[2:0]});
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // address moved after capture, data changed before close (R2)
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input bit ce_ctl);
    @(negedge clk);
    if (ce_ctl) begin
      we_n = 1'b0; addr = ~a; dq_in = ~d;
      @(negedge clk);
    end
    ce_n = 1'b0; we_n = 1'b0; addr = a; dq_in = ~d;
    @(negedge clk);
    addr = a ^ 16'h1FFF; dq_in = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; dq_in = 8'h00;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk);
    d = dq_out;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_program(input logic [15:0] a, input logic [7:0] d);
    bus_write(16'h5555, 8'hAA, 0);
    bus_write(16'h2AAA, 8'h55, 0);
    bus_write(16'h5555, 8'hA0, 0);
    bus_write(a, d, 1);
  endtask

  task automatic erase_prefix();
    bus_write(16'h5555, 8'hAA, 0);
    bus_write(16'h2AAA, 8'h55, 0);
    bus_write(16'h5555, 8'h80, 0);
    bus_write(16'h5555, 8'hAA, 0);
    bus_write(16'h2AAA, 8'h55, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_byte(input logic [15:0] a, input string req);
    logic [7:0] v;
    bus_read(a, v);
    chk(v == shadow[midx(a)], req, v, shadow[midx(a)]);
  endtask

  initial begin
    logic [7:0] v, s0, s1;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 128; i++) shadow[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset contents
    expect_byte(16'h0000, "R1");
    expect_byte(16'hF007, "R1");

    // R10 output enable
    ce_n = 1'b1; oe_n = 1'b0; #1;
    chk(dq_oe == 1'b0 && dq_out == 8'h00, "R10 ce high", {dq_oe, dq_out}, 0);
    ce_n = 1'b0; oe_n = 1'b1; #1;
    chk(dq_oe == 1'b0 && dq_out == 8'h00, "R10 oe high", {dq_oe, dq_out}, 0);
    oe_n = 1'b0; #1;
    chk(dq_oe == 1'b1, "R10 both low", dq_oe, 1);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);

    // R3/R2 program with chip-enable controlled write, R8/R9 status
    do_program(16'h1234, 8'h5A);
    bus_read(16'h1234, s0);
    bus_read(16'h1234, s1);
    chk(s0[7] == 1'b1, "R8 program poll", s0[7], 1);
    chk(s0[5:0] == 6'b0, "R8 low bits", s0[5:0], 0);
    chk(s0[6] == 1'b0 && s1[6] == 1'b1, "R9 toggle", {s0[6], s1[6]}, 1);
    idle(30);
    shadow[midx(16'h1234)] = 8'h5A;
    expect_byte(16'h1234, "R2/R3/R11 program");

    // R3 AND semantics
    do_program(16'h1234, 8'hF0);
    idle(30);
    shadow[midx(16'h1234)] &= 8'hF0;
    expect_byte(16'h1234, "R3 and");

    // R12 aliasing of offset bits 3..11
    bus_read(16'h1334, v);
    chk(v == 8'h50, "R12 alias", v, 8'h50);

    // R6 broken sequences
    bus_write(16'h5555, 8'hAA, 0);
    bus_write(16'h2AAA, 8'h55, 0);
    bus_write(16'h5555, 8'h77, 0);
    bus_write(16'h2000, 8'h00, 0);
    idle(30);
    expect_byte(16'h2000, "R6 bad data");
    bus_write(16'h5555, 8'hAA, 0);
    bus_write(16'h1AAA, 8'h55, 0);
    bus_write(16'h5555, 8'hA0, 0);
    bus_write(16'h2001, 8'h00, 0);
    idle(30);
    expect_byte(16'h2001, "R6 bad address");

    // R4 sector erase
    do_program(16'h3001, 8'h11); idle(30); shadow[midx(16'h3001)] = 8'h11;
    do_program(16'h4002, 8'h22); idle(30); shadow[midx(16'h4002)] = 8'h22;
    erase_prefix();
    bus_write(16'h3FFF, 8'h30, 0);
    bus_read(16'h3001, v);
    chk(v[7] == 1'b0, "R8 erase poll", v[7], 0);
    idle(70);
    for (int i = 0; i < 8; i++) shadow[midx(16'h3000) + i] = 8'hFF;
    expect_byte(16'h3001, "R4 erased");
    expect_byte(16'h4002, "R4 other sector");

    // R7 chip erase sequence while a sector erase runs
    erase_prefix();
    bus_write(16'h4000, 8'h30, 0);
    erase_prefix();
    bus_write(16'h5555, 8'h10, 0);
    idle(70);
    for (int i = 0; i < 8; i++) shadow[midx(16'h4000) + i] = 8'hFF;
    expect_byte(16'h4002, "R7 sector erase ran");
    expect_byte(16'h1234, "R7 chip erase ignored");

    // R7 unlock byte during program must not count
    do_program(16'h0010, 8'h0F);
    bus_write(16'h5555, 8'hAA, 0);
    idle(30);
    bus_write(16'h2AAA, 8'h55, 0);
    bus_write(16'h5555, 8'hA0, 0);
    bus_write(16'h0011, 8'h00, 0);
    idle(30);
    shadow[midx(16'h0010)] = 8'h0F;
    expect_byte(16'h0011, "R7 write ignored");
    expect_byte(16'h0010, "R3 program");

    // random programs against the shadow (R3, R12)
    for (int k = 0; k < 40; k++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = 16'($urandom);
      d = 8'($urandom);
      if (a[14:0] == 15'h5555 || a[14:0] == 15'h2AAA) a[15] = ~a[15];
      do_program(a, d);
      idle(24);
      shadow[midx(a)] &= d;
      expect_byte(a ^ 16'h0FF8, "R3/R12 random");
    end

    // R5 chip erase
    erase_prefix();
    bus_write(16'h5555, 8'h10, 0);
    bus_read(16'h0000, v);
    chk(v[7] == 1'b0, "R8 chip poll", v[7], 0);
    idle(130);
    for (int i = 0; i < 128; i++) shadow[i] = 8'hFF;
    for (int k = 0; k < 8; k++) expect_byte(16'($urandom), "R5 chip erased");
    expect_byte(16'h1234, "R5 chip erased");

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule